// File: doc/BRIEF.md
# Two-Level Network Address Translator

The block turns a network logical address into a physical memory address for a requesting functional unit. A request carries a logical page index, a byte offset, the requester's process ID and the access kinds it wants. The upper bits of the page index select one entry of an on-chip base table. That entry holds the base of a 2 MB translation table in memory, which maps up to 2^18 pages. The lower 18 bits select one 64-bit translation entry inside that table.

A small fully associative cache of translation entries is searched first. On a miss, the block reads the base-table entry and then issues exactly one 64-bit memory read for the translation entry. Every entry, whether it comes from the cache or from memory, is checked against the requester's process ID and access bits, and its size code is checked. The block then returns either a physical address or a fault. A fetched entry that passes the checks goes into the cache, with round-robin replacement.

64-bit translation entry layout: bits 63:59 size code, bits 58:52 reserved, bits 51:12 physical page address, bits 11:2 process ID, bits 1:0 permitted access. A page is 2^size × 4 KB.

Top module: `nat_xlate`

## Requirements
- R1: After reset, req_ready is 1 and rsp_valid and mem_req_valid are 0.
- R2: A cache miss on a valid base-table entry raises mem_req_valid two cycles after the request is accepted. mem_req_addr = {base-table base, page index bits 17:0, 3'b000}, where the base-table index is page index bits 27:18. Request and address are held until mem_req_ready is seen. Exactly one read is made per miss, and the response follows one cycle after mem_rsp_valid.
- R3: A cache miss whose base-table entry is invalid gives a fault response two cycles after acceptance, and no memory read is made.
- R4: For size codes 0, 1, 4, 9 and 18, rsp_addr is the page address {bits 51:12, 12'b0} with its lowest 12+size bits replaced by the same bits of the offset.
- R5: A process ID that differs from entry bits 11:2 gives a fault with rsp_addr 0.
- R6: req_acc bit 0 means read and bit 1 means write. A fault results if any requested bit is clear in entry bits 1:0.
- R7: Any other size code, or nonzero reserved bits 58:52, gives a fault.
- R8: A fetched entry that passes is cached. A later request for the same page index hits and responds one cycle after acceptance, with no memory read.
- R9: A fetched entry that faults is not cached, so repeating the request makes another memory read.
- R10: A cache hit is checked in the same way, so a hit with a wrong process ID faults.
- R11: With the default four cache slots, insertions fill the slots in round-robin order. The fifth distinct insertion evicts the first.
- R12: A base-table write to the index being read, in the same cycle as the read, does not affect that read. The old contents are used and the new contents apply from the next request on.
- R13: req_ready is low from the cycle after acceptance until the response. rsp_valid is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bt_wr_en | input | 1 | Base-table write strobe |
| bt_wr_idx | input | 10 | Base-table index written |
| bt_wr_valid | input | 1 | Valid flag written |
| bt_wr_base | input | 31 | Table base (physical address bits 51:21) written |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_pgi | input | 28 | Logical page index |
| req_off | input | 30 | Byte offset |
| req_vpid | input | 10 | Requester process ID |
| req_acc | input | 2 | Requested access, bit 0 read, bit 1 write |
| rsp_valid | output | 1 | Response pulse |
| rsp_fault | output | 1 | Translation refused |
| rsp_addr | output | 52 | Physical address, 0 on fault |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 52 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 64 | Entry data |

## Verification
Two things can fall in the same cycle: a base-table write from the configuration port, and the base-table read that a missing translation makes. The bench provokes this by writing the index under lookup, marking it invalid, in exactly the cycle after acceptance. The behavioural model expects that translation to complete with the old contents, and it expects the next miss on that index to fault without a memory read. Cache insertion and replacement are judged in the same way: the model decides hit or miss for every request from its own round-robin list, and compares response timing, memory traffic and results on every clock.

// File: rtl/nat_pkg.sv
package nat_pkg;
  localparam int PA_W   = 52;
  localparam int VPID_W = 10;
  localparam int PG_SH  = 12;

  typedef struct packed {
    logic [4:0]        size;
    logic [6:0]        rsvd;
    logic [39:0]       ppa;
    logic [VPID_W-1:0] vpid;
    logic [1:0]        acc;
  } nat_entry_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOOKUP, ST_BTCHK, ST_MEMREQ, ST_WAIT
  } nat_state_t;
endpackage

// File: rtl/nat_base_table.sv
module nat_base_table #(
  parameter int DEPTH  = 1024,
  parameter int BASE_W = 31,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_valid,
  input  logic [BASE_W-1:0] wr_base,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [BASE_W-1:0] rd_base
);
  logic [DEPTH-1:0]  vld_q;
  logic [BASE_W-1:0] base_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else if (wr_en) vld_q[wr_idx] <= wr_valid;
  end

  always_ff @(posedge clk) begin
    if (wr_en) base_q[wr_idx] <= wr_base;
  end

  // read uses the contents held before any write of this edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid <= 1'b0;
    else if (rd_en) rd_valid <= vld_q[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_base <= base_q[rd_idx];
  end
endmodule

// File: rtl/nat_tlb.sv
module nat_tlb #(
  parameter int DEPTH = 4,
  parameter int TAG_W = 28,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             hit,
  output logic [63:0]      hit_entry,
  input  logic             ins_en,
  input  logic [TAG_W-1:0] ins_tag,
  input  logic [63:0]      ins_entry
);
  logic [DEPTH-1:0] vld_q;
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [63:0]      ent_q [DEPTH];
  logic [DEPTH-1:0] hit_vec;
  logic [PTR_W-1:0] ptr_q, ptr_d;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign hit_vec[i] = vld_q[i] && (tag_q[i] == lk_tag);
  end

  assign hit = |hit_vec;

  always_comb begin
    hit_entry = '0;
    for (int i = 0; i < DEPTH; i++)
      if (hit_vec[i]) hit_entry = hit_entry | ent_q[i];
  end

  always_comb begin
    ptr_d = ptr_q;
    if (ins_en) ptr_d = (ptr_q == PTR_W'(DEPTH-1)) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      ptr_q <= '0;
    end else begin
      ptr_q <= ptr_d;
      if (ins_en) vld_q[ptr_q] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ins_en) begin
      tag_q[ptr_q] <= ins_tag;
      ent_q[ptr_q] <= ins_entry;
    end
  end

  a_r11_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
  a_r8_no_dup_insert: assert property (@(posedge clk) disable iff (!rst_n)
    ins_en |-> !hit);
endmodule

// File: rtl/nat_check.sv
module nat_check
  import nat_pkg::*;
#(
  parameter int OFF_W = 30
) (
  input  logic [63:0]       entry,
  input  logic [VPID_W-1:0] vpid,
  input  logic [1:0]        acc,
  input  logic [OFF_W-1:0]  off,
  output logic              fault,
  output logic [PA_W-1:0]   pa
);
  nat_entry_t e;
  logic       size_ok;
  logic [PA_W-1:0] mask;

  assign e = entry;

  always_comb begin
    case (e.size)
      5'd0, 5'd1, 5'd4, 5'd9, 5'd18: size_ok = 1'b1;
      default:                       size_ok = 1'b0;
    endcase
  end

  assign mask  = size_ok ? ((PA_W'(1) << (PG_SH + int'(e.size))) - PA_W'(1)) : '0;
  assign fault = !size_ok || (e.rsvd != '0) || (e.vpid != vpid) || ((acc & ~e.acc) != 2'b00);
  assign pa    = ({e.ppa, {PG_SH{1'b0}}} & ~mask) | (PA_W'(off) & mask);
endmodule

// File: rtl/nat_xlate.sv
module nat_xlate
  import nat_pkg::*;
#(
  parameter int BT_DEPTH    = 1024,
  parameter int ENTRY_IDX_W = 18,
  parameter int TLB_DEPTH   = 4,
  parameter int OFF_W       = 30,
  localparam int BT_IDX_W   = $clog2(BT_DEPTH),
  localparam int PGI_W      = BT_IDX_W + ENTRY_IDX_W,
  localparam int BASE_W     = PA_W - ENTRY_IDX_W - 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bt_wr_en,
  input  logic [BT_IDX_W-1:0] bt_wr_idx,
  input  logic                bt_wr_valid,
  input  logic [BASE_W-1:0]   bt_wr_base,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [PGI_W-1:0]    req_pgi,
  input  logic [OFF_W-1:0]    req_off,
  input  logic [VPID_W-1:0]   req_vpid,
  input  logic [1:0]          req_acc,
  output logic                rsp_valid,
  output logic                rsp_fault,
  output logic [PA_W-1:0]     rsp_addr,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic [PA_W-1:0]     mem_req_addr,
  input  logic                mem_rsp_valid,
  input  logic [63:0]         mem_rsp_data
);
  logic [1:0]  sync_q;
  logic        rst_i_n;
  nat_state_t  state_q, state_d;
  logic [PGI_W-1:0]  r_pgi;
  logic [OFF_W-1:0]  r_off;
  logic [VPID_W-1:0] r_vpid;
  logic [1:0]        r_acc;
  logic              accept;
  logic              tlb_hit, ins_en, bt_rd_en, bt_valid;
  logic [63:0]       tlb_entry, chk_entry;
  logic [BASE_W-1:0] bt_base;
  logic              chk_fault;
  logic [PA_W-1:0]   chk_pa;
  logic              rsp_set, rsp_fault_d;
  logic [PA_W-1:0]   rsp_addr_d;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_i_n = sync_q[1];

  assign req_ready     = (state_q == ST_IDLE);
  assign accept        = req_valid && req_ready;
  assign bt_rd_en      = (state_q == ST_LOOKUP) && !tlb_hit;
  assign mem_req_valid = (state_q == ST_MEMREQ);
  assign mem_req_addr  = {bt_base, r_pgi[ENTRY_IDX_W-1:0], 3'b000};
  assign chk_entry     = (state_q == ST_WAIT) ? mem_rsp_data : tlb_entry;
  assign ins_en        = (state_q == ST_WAIT) && mem_rsp_valid && !chk_fault;

  nat_base_table #(.DEPTH(BT_DEPTH), .BASE_W(BASE_W)) u_bt (
    .clk(clk), .rst_n(rst_i_n),
    .wr_en(bt_wr_en), .wr_idx(bt_wr_idx), .wr_valid(bt_wr_valid), .wr_base(bt_wr_base),
    .rd_en(bt_rd_en), .rd_idx(r_pgi[PGI_W-1 -: BT_IDX_W]),
    .rd_valid(bt_valid), .rd_base(bt_base)
  );

  nat_tlb #(.DEPTH(TLB_DEPTH), .TAG_W(PGI_W)) u_tlb (
    .clk(clk), .rst_n(rst_i_n),
    .lk_tag(r_pgi), .hit(tlb_hit), .hit_entry(tlb_entry),
    .ins_en(ins_en), .ins_tag(r_pgi), .ins_entry(mem_rsp_data)
  );

  nat_check #(.OFF_W(OFF_W)) u_chk (
    .entry(chk_entry), .vpid(r_vpid), .acc(r_acc), .off(r_off),
    .fault(chk_fault), .pa(chk_pa)
  );

  always_comb begin
    state_d     = state_q;
    rsp_set     = 1'b0;
    rsp_fault_d = 1'b0;
    case (state_q)
      ST_IDLE:   if (req_valid) state_d = ST_LOOKUP;
      ST_LOOKUP: begin
        if (tlb_hit) begin
          rsp_set     = 1'b1;
          rsp_fault_d = chk_fault;
          state_d     = ST_IDLE;
        end else begin
          state_d = ST_BTCHK;
        end
      end
      ST_BTCHK: begin
        if (!bt_valid) begin
          rsp_set     = 1'b1;
          rsp_fault_d = 1'b1;
          state_d     = ST_IDLE;
        end else begin
          state_d = ST_MEMREQ;
        end
      end
      ST_MEMREQ: if (mem_req_ready) state_d = ST_WAIT;
      ST_WAIT: begin
        if (mem_rsp_valid) begin
          rsp_set     = 1'b1;
          rsp_fault_d = chk_fault;
          state_d     = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    rsp_addr_d = rsp_fault_d ? '0 : chk_pa;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q   <= ST_IDLE;
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_addr  <= '0;
    end else begin
      state_q   <= state_d;
      rsp_valid <= rsp_set;
      if (rsp_set) begin
        rsp_fault <= rsp_fault_d;
        rsp_addr  <= rsp_addr_d;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      r_pgi  <= req_pgi;
      r_off  <= req_off;
      r_vpid <= req_vpid;
      r_acc  <= req_acc;
    end
  end

  a_r13_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_i_n)
    rsp_valid |=> !rsp_valid);
  a_r13_busy: assert property (@(posedge clk) disable iff (!rst_i_n)
    accept |=> !req_ready);
  a_r2_mem_hold: assert property (@(posedge clk) disable iff (!rst_i_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
  a_r3_invalid_fault: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state_q == ST_BTCHK && !bt_valid) |=> (rsp_valid && rsp_fault && !mem_req_valid));
  a_r5_fault_zero_addr: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rsp_valid && rsp_fault) |-> (rsp_addr == '0));
endmodule

// File: tb/tb_nat_xlate.sv
module tb_nat_xlate;
  logic        clk, rst_n;
  logic        bt_wr_en, bt_wr_valid;
  logic [9:0]  bt_wr_idx;
  logic [30:0] bt_wr_base;
  logic        req_valid, req_ready;
  logic [27:0] req_pgi;
  logic [29:0] req_off;
  logic [9:0]  req_vpid;
  logic [1:0]  req_acc;
  logic        rsp_valid, rsp_fault;
  logic [51:0] rsp_addr;
  logic        mem_req_valid, mem_req_ready;
  logic [51:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;

  int nchecks = 0;
  int nerr = 0;

  // behavioural model state
  bit          m_bvld [1024];
  logic [30:0] m_bbase [1024];
  logic [63:0] m_mem [logic [51:0]];
  bit          m_tv [4];
  logic [27:0] m_tt [4];
  logic [63:0] m_te [4];
  int          m_rr = 0;

  nat_xlate dut (
    .clk(clk), .rst_n(rst_n),
    .bt_wr_en(bt_wr_en), .bt_wr_idx(bt_wr_idx), .bt_wr_valid(bt_wr_valid), .bt_wr_base(bt_wr_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_pgi(req_pgi), .req_off(req_off),
    .req_vpid(req_vpid), .req_acc(req_acc),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_addr(rsp_addr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic ck(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchecks++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input int sz, input int rs, input logic [39:0] ppa,
                                     input logic [9:0] vp, input logic [1:0] ac);
    logic [4:0] s5 = sz[4:0];
    logic [6:0] r7 = rs[6:0];
    return {s5, r7, ppa, vp, ac};
  endfunction

  function automatic void mchk(input logic [63:0] e, input logic [9:0] vp, input logic [1:0] ac,
                               input logic [29:0] off, output bit f, output logic [51:0] pa);
    int s = int'(e[63:59]);
    bit ok = (s == 0 || s == 1 || s == 4 || s == 9 || s == 18) && (e[58:52] == 7'd0);
    longint unsigned pg, base, o;
    f = !ok || (e[11:2] != vp) || ((ac & ~e[1:0]) != 2'b00);
    pg = 64'd4096 << s;
    base = {12'd0, e[51:12], 12'h000};
    o = {34'd0, off};
    pa = f ? 52'd0 : 52'((base - base % pg) + (o % pg));
  endfunction

  task automatic bt_write(input int idx, input bit v, input logic [30:0] b);
    @(negedge clk);
    bt_wr_en = 1'b1; bt_wr_idx = idx[9:0]; bt_wr_valid = v; bt_wr_base = b;
    @(negedge clk);
    bt_wr_en = 1'b0;
    m_bvld[idx] = v; m_bbase[idx] = b;
  endtask

  task automatic xlate(input logic [27:0] pgi, input logic [29:0] off, input logic [9:0] vp,
                       input logic [1:0] ac, input int lat, input bit collide, input string tag);
    int slot = -1;
    int path;
    int bi = int'(pgi[27:18]);
    bit ef;
    logic [51:0] ea, maddr;
    logic [63:0] ent;
    for (int i = 0; i < 4; i++) if (m_tv[i] && m_tt[i] == pgi) slot = i;
    path = (slot >= 0) ? 0 : (m_bvld[bi] ? 2 : 1);
    maddr = {m_bbase[bi], pgi[17:0], 3'b000};
    // N0
    @(negedge clk);
    ck(req_ready == 1'b1, {tag, " R13 ready idle"}, 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_pgi = pgi; req_off = off; req_vpid = vp; req_acc = ac;
    // N1: lookup cycle
    @(negedge clk);
    req_valid = 1'b0;
    ck(req_ready == 1'b0, {tag, " R13 busy"}, 64'(req_ready), 64'd0);
    ck(rsp_valid == 1'b0, {tag, " R13 no early rsp"}, 64'(rsp_valid), 64'd0);
    if (collide) begin
      bt_wr_en = 1'b1; bt_wr_idx = pgi[27:18]; bt_wr_valid = 1'b0; bt_wr_base = 31'd0;
      m_bvld[bi] = 1'b0;
    end
    // N2
    @(negedge clk);
    bt_wr_en = 1'b0;
    if (path == 0) begin
      mchk(m_te[slot], vp, ac, off, ef, ea);
      ck(rsp_valid == 1'b1, {tag, " R8 hit timing"}, 64'(rsp_valid), 64'd1);
      ck(rsp_fault == ef, {tag, " R10 hit fault"}, 64'(rsp_fault), 64'(ef));
      ck(rsp_addr == ea, {tag, " R4 hit addr"}, 64'(rsp_addr), 64'(ea));
      ck(mem_req_valid == 1'b0, {tag, " R8 no mem read"}, 64'(mem_req_valid), 64'd0);
    end else begin
      ck(rsp_valid == 1'b0 && mem_req_valid == 1'b0, {tag, " R2 idle N2"},
         64'({rsp_valid, mem_req_valid}), 64'd0);
      // N3
      @(negedge clk);
      if (path == 1) begin
        ck(rsp_valid == 1'b1 && rsp_fault == 1'b1, {tag, " R3 invalid fault"},
           64'({rsp_valid, rsp_fault}), 64'd3);
        ck(mem_req_valid == 1'b0, {tag, " R3 no mem read"}, 64'(mem_req_valid), 64'd0);
      end else begin
        ck(mem_req_valid == 1'b1, {tag, " R2 mem req"}, 64'(mem_req_valid), 64'd1);
        ck(mem_req_addr == maddr, {tag, " R2 mem addr"}, 64'(mem_req_addr), 64'(maddr));
        @(negedge clk);
        ck(mem_req_valid == 1'b1 && mem_req_addr == maddr, {tag, " R2 hold"},
           64'(mem_req_addr), 64'(maddr));
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        ck(mem_req_valid == 1'b0, {tag, " R2 single read"}, 64'(mem_req_valid), 64'd0);
        for (int k = 0; k < lat; k++) begin
          @(negedge clk);
          ck(rsp_valid == 1'b0 && mem_req_valid == 1'b0, {tag, " R2 waiting"},
             64'({rsp_valid, mem_req_valid}), 64'd0);
        end
        ent = m_mem.exists(maddr) ? m_mem[maddr] : 64'd0;
        mem_rsp_valid = 1'b1; mem_rsp_data = ent;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        mchk(ent, vp, ac, off, ef, ea);
        ck(rsp_valid == 1'b1, {tag, " R2 rsp after data"}, 64'(rsp_valid), 64'd1);
        ck(rsp_fault == ef, {tag, " R5 R6 R7 fault"}, 64'(rsp_fault), 64'(ef));
        ck(rsp_addr == ea, {tag, " R4 addr"}, 64'(rsp_addr), 64'(ea));
        if (!ef) begin
          m_tv[m_rr] = 1'b1; m_tt[m_rr] = pgi; m_te[m_rr] = ent;
          m_rr = (m_rr + 1) % 4;
        end
      end
    end
    @(negedge clk);
    ck(rsp_valid == 1'b0, {tag, " R13 pulse"}, 64'(rsp_valid), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    bt_wr_en = 0; bt_wr_idx = 0; bt_wr_valid = 0; bt_wr_base = 0;
    req_valid = 0; req_pgi = 0; req_off = 0; req_vpid = 0; req_acc = 0;
    mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = 0;
    for (int i = 0; i < 1024; i++) m_bvld[i] = 1'b0;
    for (int i = 0; i < 4; i++) m_tv[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    ck(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_req_valid == 1'b0, "R1 reset state",
       64'({req_ready, rsp_valid, mem_req_valid}), 64'd4);

    bt_write(5, 1'b1, 31'h0000_0ABC);
    bt_write(7, 1'b1, 31'h0001_2345);
    m_mem[{31'h0000_0ABC, 18'd7, 3'b000}]  = mk(0, 0, 40'hAB_CDEF_1357, 10'd3, 2'b11);
    m_mem[{31'h0000_0ABC, 18'd8, 3'b000}]  = mk(0, 0, 40'h11_2233_4455, 10'd3, 2'b01);
    m_mem[{31'h0000_0ABC, 18'd9, 3'b000}]  = mk(0, 0, 40'h55_6677_8899, 10'd7, 2'b11);
    m_mem[{31'h0000_0ABC, 18'd10, 3'b000}] = mk(1, 0, 40'hAB_CDEF_1357, 10'd1, 2'b11);
    m_mem[{31'h0000_0ABC, 18'd11, 3'b000}] = mk(4, 0, 40'hAB_CDEF_1357, 10'd1, 2'b11);
    m_mem[{31'h0000_0ABC, 18'd12, 3'b000}] = mk(9, 0, 40'hAB_CDEF_1357, 10'd1, 2'b11);
    m_mem[{31'h0000_0ABC, 18'd13, 3'b000}] = mk(18, 0, 40'hAB_CDEF_1357, 10'd1, 2'b11);
    m_mem[{31'h0000_0ABC, 18'd14, 3'b000}] = mk(2, 0, 40'hAB_CDEF_1357, 10'd1, 2'b11);
    m_mem[{31'h0000_0ABC, 18'd15, 3'b000}] = mk(31, 0, 40'hAB_CDEF_1357, 10'd1, 2'b11);
    m_mem[{31'h0000_0ABC, 18'd16, 3'b000}] = mk(0, 5, 40'hAB_CDEF_1357, 10'd1, 2'b11);
    m_mem[{31'h0001_2345, 18'd3, 3'b000}]  = mk(0, 0, 40'h99_8877_6655, 10'd2, 2'b10);

    xlate({10'd5, 18'd7}, 30'h3FFF_FFFF, 10'd3, 2'b01, 2, 0, "R2 R4 miss size0");
    xlate({10'd5, 18'd7}, 30'h0000_0123, 10'd3, 2'b11, 0, 0, "R8 hit");
    xlate({10'd5, 18'd7}, 30'h0000_0123, 10'd4, 2'b01, 0, 0, "R10 hit vpid");
    xlate({10'd5, 18'd8}, 30'h0000_0010, 10'd3, 2'b10, 1, 0, "R6 write denied");
    xlate({10'd5, 18'd8}, 30'h0000_0010, 10'd3, 2'b10, 0, 0, "R9 refetch");
    xlate({10'd5, 18'd9}, 30'h0000_0010, 10'd6, 2'b01, 3, 0, "R5 vpid miss");
    xlate({10'd5, 18'd10}, 30'h3FFF_FFFF, 10'd1, 2'b01, 0, 0, "R4 size1");
    xlate({10'd5, 18'd11}, 30'h3FFF_FFFF, 10'd1, 2'b10, 1, 0, "R4 size4");
    xlate({10'd5, 18'd12}, 30'h3FFF_FFFF, 10'd1, 2'b11, 2, 0, "R4 size9");
    xlate({10'd5, 18'd13}, 30'h2AAA_AAAA, 10'd1, 2'b01, 0, 0, "R4 R11 size18 evicts first");
    xlate({10'd5, 18'd14}, 30'h0000_0001, 10'd1, 2'b01, 0, 0, "R7 size2");
    xlate({10'd5, 18'd15}, 30'h0000_0001, 10'd1, 2'b01, 0, 0, "R7 size31");
    xlate({10'd5, 18'd16}, 30'h0000_0001, 10'd1, 2'b01, 0, 0, "R7 reserved");
    xlate({10'd5, 18'd10}, 30'h0000_0FFF, 10'd1, 2'b01, 0, 0, "R11 second still hits");
    xlate({10'd5, 18'd7}, 30'h0000_0FFF, 10'd3, 2'b01, 1, 0, "R11 first evicted");
    xlate({10'd5, 18'd11}, 30'h0000_0FFF, 10'd1, 2'b01, 0, 0, "R11 third hits");
    xlate({10'd5, 18'd10}, 30'h0000_0FFF, 10'd1, 2'b01, 0, 0, "R11 second evicted");
    xlate({10'd6, 18'd1}, 30'h0000_0000, 10'd1, 2'b01, 0, 0, "R3 invalid base");
    xlate({10'd7, 18'd3}, 30'h0000_0ABC, 10'd2, 2'b10, 1, 1, "R12 collide old used");
    xlate({10'd7, 18'd4}, 30'h0000_0ABC, 10'd2, 2'b10, 0, 0, "R12 R3 new applies");

    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end
endmodule